// File: doc/BRIEF.md
# Pending Message-Interrupt Priority Scanner

This block keeps track of the most urgent pending message-signalled interrupt for one processor. Pending state is held as one bit per interrupt ID in a bitmap in external memory, and each ID also owns one configuration byte in a second table that carries an enable flag and a priority. The block reaches both tables through a single byte-wide read/write memory port with a request/acknowledge handshake and any latency.

When message interrupts become enabled it walks the whole pending bitmap, starting at the first message-interrupt ID (8192), reads the configuration byte of every pending ID it meets and keeps the best candidate. Afterwards it accepts single set and clear requests for individual IDs on a valid/ready stream. Each request is applied by read-modify-write of the pending byte. A set refreshes the best candidate by comparing only that one ID. A clear of the current best starts a full rescan. The result is presented as an ID, a priority, a valid flag and a group code.

The request stream applies back-pressure: `req_ready` is high only while the block is idle and no rescan is waiting to start. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. The requester holds ID and direction stable until then. Control inputs (enable, table bases, ID-width field, security mode) are plain levels.

Top module: `lpi_prio_scanner`

## Requirements
- R1: After reset `best_valid` is 0, `best_prio` is 0xFF, `best_group` is 0, `busy` is 0, `mem_req` is 0, and no memory access is made while idle.
- R2: The block is active only while `lpi_en` is 1 and both `prop_base` and `pend_base` are nonzero. Otherwise no scan starts and accepted requests are dropped without any memory access.
- R3: The effective ID-bit count is min(`id_bits_cfg`, MAX_IDBITS). The table covers 2^(count+1) IDs. A rise of the activity condition of R2 causes one full scan. The scan first resets the best priority to 0xFF, then reads pending bytes at `pend_base`+i for i from 1024 to the last byte of the table. A table of 8192 IDs or fewer yields no candidate.
- R4: Inside a pending byte, set bits are handled from bit 0 upward, and the ID is byte index*8 + bit index. The configuration byte of an ID is read at `prop_base` + (ID − 8192). Bit 0 of that byte is the enable, and a pending ID whose enable is 0 never becomes the best.
- R5: The candidate priority is (cfg & 0xFC) when `sec_off` is 1, and 0x80 | ((cfg & 0xFC) >> 1) when `sec_off` is 0.
- R6: A candidate replaces the best when its priority is numerically lower, or when the priorities are equal and its ID is less than or equal to the best ID.
- R7: A request whose ID is below 8192 or above 2^(count+1)−1 is dropped with no memory access.
- R8: For a valid request the pending byte at `pend_base` + ID/8 is read. Bit ID%8 is set (`req_set`=1) or cleared (`req_set`=0), and the byte is written back only if that bit changes.
- R9: After a set that changes the bit, only that ID's configuration is read and compared against the best. No rescan happens, so pending bits written to memory by others are not picked up.
- R10: A clear that changes the bit of the current valid best starts a full scan as in R3. A clear of any other ID leaves the best unchanged.
- R11: `best_valid` is 0 exactly when the best priority is 0xFF. `best_group` is 2'b10 (non-secure group 1) when valid and 2'b00 otherwise.
- R12: `mem_req` stays high with stable address, direction and write data until `mem_ack`. `busy` is high during every scan or update. `req_ready` is high only when not busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lpi_en | input | 1 | Message-interrupt enable |
| sec_off | input | 1 | 1 = single security state (raw priority view) |
| prop_base | input | ADDR_W | Byte address of the configuration table |
| pend_base | input | ADDR_W | Byte address of the pending bitmap |
| id_bits_cfg | input | 5 | Programmed ID-bit count |
| req_valid | input | 1 | Set/clear request present |
| req_ready | output | 1 | Request accepted this edge if valid |
| req_id | input | MAX_IDBITS+1 | Interrupt ID of the request |
| req_set | input | 1 | 1 = mark pending, 0 = clear pending |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = byte write, 0 = byte read |
| mem_addr | output | ADDR_W | Byte address |
| mem_wdata | output | 8 | Write data |
| mem_ack | input | 1 | One-cycle completion pulse |
| mem_rdata | input | 8 | Read data, valid with `mem_ack` |
| busy | output | 1 | Scan or update in progress |
| best_valid | output | 1 | A best candidate exists |
| best_id | output | MAX_IDBITS+1 | ID of the best candidate |
| best_prio | output | 8 | Priority of the best candidate |
| best_group | output | 2 | Group code of the best candidate |

## Verification
The bench places a disabled entry with priority 0 in front of enabled ones. A design that skipped the enable test would report it. It also places candidates at the very last table byte and just beyond it, and scans again with the ID-width field above the maximum, so an off-by-one end address or a missing clamp shows up as a wrong or missing winner. Equal-priority ties are tested both within a scan and through a set request for a lower ID, which a strict less-than comparison would not accept. Set and clear requests that do not change the bit, that hit a non-best ID, or that lie outside the table are counted against memory writes and reads, so an unconditional write-back, a stray rescan or a missed range check changes the counts or the reported winner.

// File: rtl/lpi_scan_pkg.sv
package lpi_scan_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PEND_RD,
    ST_PEND_BIT,
    ST_CFG_RD,
    ST_UPD_RD,
    ST_UPD_WR
  } scan_state_e;

  localparam logic [7:0] PRIO_NONE = 8'hFF;
  localparam logic [1:0] GRP_NONE  = 2'b00;
  localparam logic [1:0] GRP_NS1   = 2'b10;
endpackage

// File: rtl/lpi_cfg_decode.sv
module lpi_cfg_decode #(
  parameter logic [7:0] PRIO_MASK = 8'hFC
) (
  input  logic [7:0] cfg_byte,
  input  logic       sec_off,
  output logic       enabled,
  output logic [7:0] prio
);
  logic [7:0] masked;

  always_comb begin
    masked  = cfg_byte & PRIO_MASK;
    enabled = cfg_byte[0];
    // R5: two views of the same field
    if (sec_off) prio = masked;
    else         prio = 8'h80 | (masked >> 1);
  end
endmodule

// File: rtl/lpi_bit_picker.sv
module lpi_bit_picker #(
  parameter int W = 8,
  localparam int IDX_W = $clog2(W)
) (
  input  logic [W-1:0]     vec,
  output logic             any,
  output logic [IDX_W-1:0] idx,
  output logic [W-1:0]     rest
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    // R4: lowest set bit wins
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) begin
        any = 1'b1;
        idx = IDX_W'(i);
      end
    end
    rest = vec & (vec - 1'b1);
  end
endmodule

// File: rtl/lpi_best_tracker.sv
module lpi_best_tracker #(
  parameter int ID_W = 15
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            offer,
  input  logic [ID_W-1:0] offer_id,
  input  logic [7:0]      offer_prio,
  output logic [ID_W-1:0] best_id,
  output logic [7:0]      best_prio
);
  import lpi_scan_pkg::*;

  logic wins;

  // R6: lower priority value wins, ties go to the lower or equal ID
  always_comb
    wins = (offer_prio < best_prio) ||
           ((offer_prio == best_prio) && (offer_id <= best_id));

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      best_prio <= PRIO_NONE;
      best_id   <= '1;
    end else if (offer && wins) begin
      best_prio <= offer_prio;
      best_id   <= offer_id;
    end
  end
endmodule

// File: rtl/lpi_prio_scanner.sv
module lpi_prio_scanner #(
  parameter int         ADDR_W     = 32,
  parameter int         MAX_IDBITS = 14,
  parameter int         FIRST_ID   = 8192,
  parameter logic [7:0] PRIO_MASK  = 8'hFC,
  localparam int        ID_W       = MAX_IDBITS + 1,
  localparam int        BYTE_W     = ID_W - 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lpi_en,
  input  logic              sec_off,
  input  logic [ADDR_W-1:0] prop_base,
  input  logic [ADDR_W-1:0] pend_base,
  input  logic [4:0]        id_bits_cfg,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ID_W-1:0]   req_id,
  input  logic              req_set,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic              mem_ack,
  input  logic [7:0]        mem_rdata,
  output logic              busy,
  output logic              best_valid,
  output logic [ID_W-1:0]   best_id,
  output logic [7:0]        best_prio,
  output logic [1:0]        best_group
);
  import lpi_scan_pkg::*;

  localparam int FIRST_BYTE = FIRST_ID / 8;

  scan_state_e       state;
  logic [BYTE_W-1:0] byte_idx;
  logic [7:0]        byte_q;
  logic [ID_W-1:0]   cur_id;
  logic              upd_set;
  logic              scan_mode;
  logic              en_q;
  logic              rescan_pend;

  logic              eff_en;
  logic [4:0]        idb_eff;
  logic [31:0]       tbl_ids;
  logic [31:0]       last_id;
  logic [31:0]       last_byte;
  logic              scan_empty;
  logic              req_in_range;
  logic              start_idle;
  logic              start_clr;
  logic              trk_clr;
  logic              trk_offer;
  logic              cfg_en;
  logic [7:0]        cfg_prio;
  logic              pick_any;
  logic [2:0]        pick_idx;
  logic [7:0]        pick_rest;
  logic [7:0]        upd_mask;
  logic              upd_bit;

  // R2 / R3: activity gate and table extent
  always_comb begin
    eff_en     = lpi_en && (|prop_base) && (|pend_base);
    idb_eff    = ({27'd0, id_bits_cfg} > 32'(MAX_IDBITS)) ? 5'(MAX_IDBITS) : id_bits_cfg;
    tbl_ids    = 32'd1 << ({27'd0, idb_eff} + 32'd1);
    last_id    = tbl_ids - 32'd1;
    last_byte  = (tbl_ids >> 3) - 32'd1;
    scan_empty = (tbl_ids >> 3) <= 32'(FIRST_BYTE);
    // R7: range test on the request ID
    req_in_range = ({{(32-ID_W){1'b0}}, req_id} >= 32'(FIRST_ID)) &&
                   ({{(32-ID_W){1'b0}}, req_id} <= last_id);
    upd_mask   = 8'd1 << cur_id[2:0];
    upd_bit    = mem_rdata[cur_id[2:0]];
  end

  always_comb begin
    req_ready  = (state == ST_IDLE) && !(rescan_pend && eff_en);
    start_idle = (state == ST_IDLE) && rescan_pend && eff_en;
    // R10: clear of the current best forces a rescan
    start_clr  = (state == ST_UPD_WR) && mem_ack && !upd_set &&
                 best_valid && (cur_id == best_id);
    trk_clr    = start_idle || start_clr;
    trk_offer  = (state == ST_CFG_RD) && mem_ack && cfg_en;
  end

  lpi_bit_picker #(.W(8)) u_pick (
    .vec  (byte_q),
    .any  (pick_any),
    .idx  (pick_idx),
    .rest (pick_rest)
  );

  lpi_cfg_decode #(.PRIO_MASK(PRIO_MASK)) u_dec (
    .cfg_byte (mem_rdata),
    .sec_off  (sec_off),
    .enabled  (cfg_en),
    .prio     (cfg_prio)
  );

  lpi_best_tracker #(.ID_W(ID_W)) u_best (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (trk_clr),
    .offer      (trk_offer),
    .offer_id   (cur_id),
    .offer_prio (cfg_prio),
    .best_id    (best_id),
    .best_prio  (best_prio)
  );

  // R12: memory port driven from state only
  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = 8'h00;
    unique case (state)
      ST_PEND_RD: begin
        mem_req  = 1'b1;
        mem_addr = pend_base + ADDR_W'(byte_idx);
      end
      ST_CFG_RD: begin
        mem_req  = 1'b1;
        mem_addr = prop_base + ADDR_W'(cur_id - ID_W'(FIRST_ID));
      end
      ST_UPD_RD: begin
        mem_req  = 1'b1;
        mem_addr = pend_base + ADDR_W'(cur_id[ID_W-1:3]);
      end
      ST_UPD_WR: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = pend_base + ADDR_W'(cur_id[ID_W-1:3]);
        mem_wdata = byte_q;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      byte_idx    <= '0;
      byte_q      <= 8'h00;
      cur_id      <= '0;
      upd_set     <= 1'b0;
      scan_mode   <= 1'b0;
      en_q        <= 1'b0;
      rescan_pend <= 1'b0;
    end else begin
      en_q <= eff_en;
      // R3: a rise of the activity gate books one full scan
      if (eff_en && !en_q)  rescan_pend <= 1'b1;
      else if (start_idle)  rescan_pend <= 1'b0;

      unique case (state)
        ST_IDLE: begin
          if (start_idle) begin
            byte_idx <= BYTE_W'(FIRST_BYTE);
            state    <= scan_empty ? ST_IDLE : ST_PEND_RD;
          end else if (req_valid && eff_en && req_in_range) begin
            cur_id  <= req_id;
            upd_set <= req_set;
            state   <= ST_UPD_RD;
          end
        end
        ST_PEND_RD: begin
          if (mem_ack) begin
            byte_q <= mem_rdata;
            state  <= ST_PEND_BIT;
          end
        end
        ST_PEND_BIT: begin
          if (pick_any) begin
            cur_id    <= {byte_idx, pick_idx};
            byte_q    <= pick_rest;
            scan_mode <= 1'b1;
            state     <= ST_CFG_RD;
          end else if ({{(32-BYTE_W){1'b0}}, byte_idx} == last_byte) begin
            state <= ST_IDLE;
          end else begin
            byte_idx <= byte_idx + 1'b1;
            state    <= ST_PEND_RD;
          end
        end
        ST_CFG_RD: begin
          if (mem_ack) state <= scan_mode ? ST_PEND_BIT : ST_IDLE;
        end
        ST_UPD_RD: begin
          if (mem_ack) begin
            // R8: write back only on a real change
            if (upd_bit == upd_set) begin
              state <= ST_IDLE;
            end else begin
              byte_q <= upd_set ? (mem_rdata | upd_mask) : (mem_rdata & ~upd_mask);
              state  <= ST_UPD_WR;
            end
          end
        end
        ST_UPD_WR: begin
          if (mem_ack) begin
            if (upd_set) begin
              // R9: only the new ID is compared
              scan_mode <= 1'b0;
              state     <= ST_CFG_RD;
            end else if (start_clr) begin
              byte_idx <= BYTE_W'(FIRST_BYTE);
              state    <= ST_PEND_RD;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R11: result flags
  always_comb begin
    busy       = (state != ST_IDLE);
    best_valid = (best_prio != PRIO_NONE);
    best_group = best_valid ? GRP_NS1 : GRP_NONE;
  end
endmodule

// File: rtl/lpi_prio_scanner_chk.sv
module lpi_prio_scanner_chk #(
  parameter int ADDR_W   = 32,
  parameter int ID_W     = 15,
  parameter int FIRST_ID = 8192
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lpi_en,
  input logic [ADDR_W-1:0] prop_base,
  input logic [ADDR_W-1:0] pend_base,
  input logic              req_ready,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [7:0]        mem_wdata,
  input logic              mem_ack,
  input logic              busy,
  input logic              best_valid,
  input logic [ID_W-1:0]   best_id,
  input logic [7:0]        best_prio
);
  p_ready_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !busy);

  p_req_held_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  p_quiet_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);

  p_gated_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(lpi_en && (|prop_base) && (|pend_base)));

  p_prio_lsb_r5: assert property (@(posedge clk) disable iff (!rst_n)
    best_valid |-> !best_prio[0]);

  p_best_is_lpi_r4: assert property (@(posedge clk) disable iff (!rst_n)
    best_valid |-> ({{(32-ID_W){1'b0}}, best_id} >= 32'(FIRST_ID)));
endmodule

bind lpi_prio_scanner lpi_prio_scanner_chk #(
  .ADDR_W   (ADDR_W),
  .ID_W     (ID_W),
  .FIRST_ID (FIRST_ID)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .lpi_en     (lpi_en),
  .prop_base  (prop_base),
  .pend_base  (pend_base),
  .req_ready  (req_ready),
  .mem_req    (mem_req),
  .mem_we     (mem_we),
  .mem_addr   (mem_addr),
  .mem_wdata  (mem_wdata),
  .mem_ack    (mem_ack),
  .busy       (busy),
  .best_valid (best_valid),
  .best_id    (best_id),
  .best_prio  (best_prio)
);

// File: tb/tb_lpi_prio_scanner.sv
module tb_lpi_prio_scanner;
  localparam int ID_W = 15;
  localparam logic [31:0] PEND = 32'h0001_0000;
  localparam logic [31:0] PROP = 32'h0002_0000;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, lpi_en, sec_off;
  logic [31:0] prop_base, pend_base;
  logic [4:0]  id_bits_cfg;
  logic        req_valid, req_ready, req_set;
  logic [ID_W-1:0] req_id;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;
  logic        busy, best_valid;
  logic [ID_W-1:0] best_id;
  logic [7:0]  best_prio;
  logic [1:0]  best_group;

  lpi_prio_scanner dut (
    .clk(clk), .rst_n(rst_n), .lpi_en(lpi_en), .sec_off(sec_off),
    .prop_base(prop_base), .pend_base(pend_base), .id_bits_cfg(id_bits_cfg),
    .req_valid(req_valid), .req_ready(req_ready), .req_id(req_id), .req_set(req_set),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .busy(busy), .best_valid(best_valid), .best_id(best_id),
    .best_prio(best_prio), .best_group(best_group)
  );

  logic [7:0] mem [logic [31:0]];
  int n_rd = 0, n_wr = 0, wcnt = 0, lat = 0;
  int n_chk = 0, n_fail = 0;

  function automatic logic [7:0] rd(logic [31:0] a);
    return mem.exists(a) ? mem[a] : 8'h00;
  endfunction

  // memory responder with 0..2 wait cycles
  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack <= 1'b0; wcnt <= 0;
    end else if (mem_ack) begin
      mem_ack <= 1'b0;
    end else if (mem_req) begin
      if (wcnt >= lat) begin
        mem_ack <= 1'b1; wcnt <= 0; lat <= (lat + 1) % 3;
        if (mem_we) begin mem[mem_addr] = mem_wdata; n_wr++; end
        else begin mem_rdata <= rd(mem_addr); n_rd++; end
      end else wcnt <= wcnt + 1;
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic set_pend(int id);
    mem[PEND + 32'(id / 8)] = rd(PEND + 32'(id / 8)) | (8'd1 << (id % 8));
  endtask

  function automatic logic pend_bit(int id);
    logic [7:0] b;
    b = rd(PEND + 32'(id / 8));
    return b[id % 8];
  endfunction

  task automatic set_cfg(int id, logic [7:0] v);
    mem[PROP + 32'(id - 8192)] = v;
  endtask

  task automatic wait_idle();
    int guard = 0;
    repeat (2) @(negedge clk);
    while (busy && guard < 60000) begin @(negedge clk); guard++; end
    check("idle reached", 32'(busy), 32'd0);
  endtask

  task automatic send_req(int id, logic s);
    @(negedge clk);
    req_valid = 1'b1; req_id = ID_W'(id); req_set = s;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    wait_idle();
  endtask

  task automatic enable_scan(logic [4:0] idb);
    @(negedge clk); lpi_en = 1'b0; id_bits_cfg = idb;
    @(negedge clk); lpi_en = 1'b1;
    repeat (2) @(negedge clk);
    wait_idle();
  endtask

  task automatic expect_best(string tag, logic v, int id, logic [7:0] p);
    check({tag, " valid"}, 32'(best_valid), 32'(v));
    check({tag, " prio"}, 32'(best_prio), 32'(p));
    if (v) check({tag, " id"}, 32'(best_id), 32'(id));
    check({tag, " group"}, 32'(best_group), v ? 32'd2 : 32'd0);
  endtask

  task automatic t_reset();
    check("R1 valid", 32'(best_valid), 0);
    check("R1 prio", 32'(best_prio), 32'hFF);
    check("R1 group", 32'(best_group), 0);
    check("R1 busy", 32'(busy), 0);
    check("R1 mem_req", 32'(mem_req), 0);
  endtask

  task automatic t_gating();
    int r0;
    @(negedge clk); prop_base = PROP; pend_base = 32'h0; id_bits_cfg = 5'd13; lpi_en = 1'b1;
    repeat (6) @(negedge clk);
    check("R2 no scan with zero pending base", 32'(busy), 0);
    check("R2 no reads", 32'(n_rd), 0);
    set_cfg(8500, 8'h31);
    send_req(8500, 1'b1);
    check("R2 request dropped, no reads", 32'(n_rd), 0);
    check("R2 request dropped, pend bit", 32'(pend_bit(8500)), 0);
    @(negedge clk); lpi_en = 1'b0; pend_base = PEND;
    r0 = n_rd;
    send_req(8500, 1'b1);
    check("R2 disabled request no reads", 32'(n_rd), 32'(r0));
    mem.delete();
  endtask

  task automatic t_scan_basic();
    sec_off = 1'b1;
    set_pend(100);
    set_pend(8195); set_cfg(8195, 8'h00);
    set_pend(8200); set_cfg(8200, 8'h41);
    set_pend(9000); set_cfg(9000, 8'h21);
    set_pend(16383); set_cfg(16383, 8'h13);
    set_pend(20000); set_cfg(20000, 8'h05);
    @(negedge clk); lpi_en = 1'b0; id_bits_cfg = 5'd13;
    @(negedge clk); lpi_en = 1'b1;
    repeat (2) @(negedge clk);
    check("R12 busy during scan", 32'(busy), 1);
    check("R12 ready low while busy", 32'(req_ready), 0);
    wait_idle();
    // R3 R4 R5: last table byte wins, disabled prio-0 entry skipped
    expect_best("R3 R4 scan winner", 1'b1, 16383, 8'h10);
    enable_scan(5'd12);
    expect_best("R3 small table empty", 1'b0, 0, 8'hFF);
    enable_scan(5'd20);
    expect_best("R3 clamp to max id bits", 1'b1, 20000, 8'h04);
  endtask

  task automatic t_tie_secure();
    mem.delete();
    @(negedge clk); sec_off = 1'b0;
    set_pend(8301); set_cfg(8301, 8'h41);
    set_pend(8302); set_cfg(8302, 8'h81);
    set_pend(8303); set_cfg(8303, 8'h41);
    enable_scan(5'd13);
    expect_best("R5 R6 secure tie in scan", 1'b1, 8301, 8'hA0);
    set_cfg(8299, 8'h41);
    send_req(8299, 1'b1);
    expect_best("R6 tie lower id replaces", 1'b1, 8299, 8'hA0);
    check("R8 set bit written", 32'(pend_bit(8299)), 1);
    set_cfg(8305, 8'h41);
    send_req(8305, 1'b1);
    expect_best("R6 tie higher id kept", 1'b1, 8299, 8'hA0);
  endtask

  task automatic t_incremental();
    int w0, r0;
    mem.delete();
    @(negedge clk); sec_off = 1'b1;
    enable_scan(5'd13);
    expect_best("R11 empty table", 1'b0, 0, 8'hFF);
    set_cfg(8500, 8'h31); set_cfg(8400, 8'h11);
    set_cfg(8600, 8'h51); set_cfg(8700, 8'h10);
    w0 = n_wr;
    send_req(8500, 1'b1);
    check("R8 one write on set", 32'(n_wr), 32'(w0 + 1));
    check("R8 pend bit 8500", 32'(pend_bit(8500)), 1);
    expect_best("R9 set updates best", 1'b1, 8500, 8'h30);
    set_pend(8400);
    send_req(8600, 1'b1);
    expect_best("R9 no rescan on set", 1'b1, 8500, 8'h30);
    w0 = n_wr;
    send_req(8500, 1'b1);
    check("R8 unchanged bit no write", 32'(n_wr), 32'(w0));
    r0 = n_rd; w0 = n_wr;
    send_req(8190, 1'b1);
    send_req(16384, 1'b1);
    check("R7 out of range no reads", 32'(n_rd), 32'(r0));
    check("R7 out of range no writes", 32'(n_wr), 32'(w0));
    send_req(8700, 1'b1);
    check("R4 disabled id pend bit", 32'(pend_bit(8700)), 1);
    expect_best("R4 disabled id ignored", 1'b1, 8500, 8'h30);
    w0 = n_wr;
    send_req(8600, 1'b0);
    check("R10 clear non-best write", 32'(n_wr), 32'(w0 + 1));
    check("R10 clear non-best bit", 32'(pend_bit(8600)), 0);
    expect_best("R10 clear non-best keeps best", 1'b1, 8500, 8'h30);
    send_req(8500, 1'b0);
    check("R8 cleared bit 8500", 32'(pend_bit(8500)), 0);
    expect_best("R10 clear best rescans", 1'b1, 8400, 8'h10);
    w0 = n_wr;
    send_req(8500, 1'b0);
    check("R8 clear of clear bit no write", 32'(n_wr), 32'(w0));
    send_req(8400, 1'b0);
    expect_best("R11 rescan finds nothing", 1'b0, 0, 8'hFF);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; lpi_en = 1'b0; sec_off = 1'b1; prop_base = '0; pend_base = '0;
    id_bits_cfg = '0; req_valid = 1'b0; req_id = '0; req_set = 1'b0; mem_rdata = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_gating();
    t_scan_basic();
    t_tie_secure();
    t_incremental();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule